// File: doc/BRIEF.md
# Page Swap Migration Sequencer

This controller exchanges the cache location of two pages that live in two different cache banks. The pages are called A and B here. It is started with the bank number and cache-side page number of each page, together with the set of cores that share each one. It then runs a fixed sequence of steps:

1. It reads the two inverse-map entries to learn the OS page numbers behind A and B, and writes those two entries back swapped.
2. It rewrites the two forward-map entries at the home banks of those OS pages.
3. It sends the new mappings to every core that shares either page, and waits until each of those cores has acknowledged.
4. It streams the blocks of both pages, alternating direction, over a block transfer port.

Both banks are held stalled for the whole operation. The map storage and the interconnect sit outside the block and are modelled as simple ports. The map read port answers one cycle after a read request. The block transfer port carries only block indices and a direction. Choosing victims when a perfect swap is not possible is left to the banks that sink the transfer.

Top module: `page_swap_seq`

## Requirements
- R1: After reset the sequencer is idle. `bank_stall`, `map_valid`, `msg_valid`, `xfer_valid` and `done` are all 0.
- R2: A `start` seen in the idle state is accepted. From the next cycle until `done`, `bank_stall` has exactly bits `bank_a` and `bank_b` set. A `start` seen in any other state is ignored and causes no later activity.
- R3: Map operations use `map_fwd`=0 for the inverse map and 1 for the forward map, and `map_we`=1 for a write. The cycles after acceptance run as follows:
  - First cycle: inverse read at (`bank_a`, `page_a`), returning Qa on `map_rdata` one cycle later.
  - Second cycle: inverse read at (`bank_b`, `page_b`), returning Qb.
  - Third cycle: inverse write at (`bank_a`, key `page_a`) with data Qb.
  - Fourth cycle: inverse write at (`bank_b`, key `page_b`) with data Qa.
- R4: In the fifth cycle there is a forward write at bank Qa[BANK_W-1:0] with key Qa and data `page_b`. In the sixth cycle there is a forward write at bank Qb[BANK_W-1:0] with key Qb and data `page_a`.
- R5: Next comes exactly one message to each core in `sharers_a | sharers_b`, in ascending core number. Each message carries `msg_os_a`=Qa, `msg_l2_a`=`page_b`, `msg_os_b`=Qb and `msg_l2_b`=`page_a`. A message advances only when `msg_ready` is 1.
- R6: No block transfer starts while any notified core has not yet acknowledged. An `ack_valid` naming a core that has no acknowledgement outstanding has no effect.
- R7: The transfer issues 2*BLOCKS beats. Beat k carries `xfer_blk`=k/2 and `xfer_dir`=k mod 2, where 0 means A to B. A beat advances only when `xfer_ready` is 1, and the outputs are held while the beat waits.
- R8: In the cycle after the last beat is accepted, `done` is 1 for exactly one cycle and `bank_stall` is 0.
- R9: With an empty sharer union, the sequencer sends no message and goes on to the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a swap |
| bank_a | input | BANK_W | Bank holding page A |
| page_a | input | PPN_W | Cache-side page number of A |
| sharers_a | input | NCORES | Cores sharing A |
| bank_b | input | BANK_W | Bank holding page B |
| page_b | input | PPN_W | Cache-side page number of B |
| sharers_b | input | NCORES | Cores sharing B |
| bank_stall | output | NBANKS | Per-bank request block |
| map_valid | output | 1 | Map operation request |
| map_we | output | 1 | 1 = write |
| map_fwd | output | 1 | 1 = forward map, 0 = inverse map |
| map_bank | output | BANK_W | Bank whose map is addressed |
| map_key | output | PPN_W | Map lookup key |
| map_wdata | output | PPN_W | Map write data |
| map_rdata | input | PPN_W | Read data, one cycle after the request |
| msg_valid | output | 1 | Mapping update message valid |
| msg_ready | input | 1 | Message accepted |
| msg_core | output | CORE_W | Destination core |
| msg_os_a | output | PPN_W | OS page formerly behind A |
| msg_l2_a | output | PPN_W | Its new cache-side page |
| msg_os_b | output | PPN_W | OS page formerly behind B |
| msg_l2_b | output | PPN_W | Its new cache-side page |
| ack_valid | input | 1 | Acknowledgement from a core |
| ack_core | input | CORE_W | Acknowledging core |
| xfer_valid | output | 1 | Block transfer beat valid |
| xfer_ready | input | 1 | Beat accepted |
| xfer_blk | output | BLK_W | Block index inside the page |
| xfer_dir | output | 1 | 0 = A to B, 1 = B to A |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state shows up at the map port within one cycle. A skipped or reordered step gives a wrong bank, key or data on the very next map operation. A corrupted captured page number shows first in the forward writes and again in every update message.

A sharer or acknowledgement vector that goes wrong shows as a missing, repeated or misordered destination core. It can also show as a transfer that starts before the last acknowledgement, or one that never starts.

A wrong beat counter shows on the first mismatching block index or direction. It also shows as a `done` pulse that comes early or late, or a stall that is not released with it.

// File: rtl/page_swap_seq.sv
module page_swap_seq #(
  parameter int NCORES = 8,
  parameter int NBANKS = 16,
  parameter int PPN_W  = 20,
  parameter int BLOCKS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [$clog2(NBANKS)-1:0] bank_a,
  input  logic [PPN_W-1:0]          page_a,
  input  logic [NCORES-1:0]         sharers_a,
  input  logic [$clog2(NBANKS)-1:0] bank_b,
  input  logic [PPN_W-1:0]          page_b,
  input  logic [NCORES-1:0]         sharers_b,
  output logic [NBANKS-1:0]         bank_stall,
  output logic                      map_valid,
  output logic                      map_we,
  output logic                      map_fwd,
  output logic [$clog2(NBANKS)-1:0] map_bank,
  output logic [PPN_W-1:0]          map_key,
  output logic [PPN_W-1:0]          map_wdata,
  input  logic [PPN_W-1:0]          map_rdata,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [$clog2(NCORES)-1:0] msg_core,
  output logic [PPN_W-1:0]          msg_os_a,
  output logic [PPN_W-1:0]          msg_l2_a,
  output logic [PPN_W-1:0]          msg_os_b,
  output logic [PPN_W-1:0]          msg_l2_b,
  input  logic                      ack_valid,
  input  logic [$clog2(NCORES)-1:0] ack_core,
  output logic                      xfer_valid,
  input  logic                      xfer_ready,
  output logic [$clog2(BLOCKS)-1:0] xfer_blk,
  output logic                      xfer_dir,
  output logic                      done
);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int CORE_W = $clog2(NCORES);
  localparam int BLK_W  = $clog2(BLOCKS);
  localparam int BEAT_W = BLK_W + 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(2 * BLOCKS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_A, S_RD_B, S_WI_A, S_WI_B, S_WF_A, S_WF_B, S_NOTIFY, S_XFER, S_DONE
  } state_t;

  state_t              state;
  logic [BANK_W-1:0]   ba, bb;
  logic [PPN_W-1:0]    pa, pb, qa, qb;
  logic [NCORES-1:0]   union_r, send_pend, ack_pend;
  logic [BEAT_W-1:0]   beat;
  logic [CORE_W-1:0]   next_core;
  logic [NCORES-1:0]   ack_mask;

  always_comb begin
    next_core = '0;
    for (int i = NCORES - 1; i >= 0; i--)
      if (send_pend[i]) next_core = CORE_W'(i);
  end

  assign ack_mask = ack_valid ? (NCORES'(1) << ack_core) : '0;

  wire busy = (state != S_IDLE) && (state != S_DONE);
  assign bank_stall = busy ? ((NBANKS'(1) << ba) | (NBANKS'(1) << bb)) : '0;
  assign done       = (state == S_DONE);

  always_comb begin
    map_valid = 1'b1;
    map_we    = 1'b1;
    map_fwd   = 1'b0;
    map_bank  = ba;
    map_key   = pa;
    map_wdata = '0;
    case (state)
      S_RD_A: map_we = 1'b0;
      S_RD_B: begin map_we = 1'b0; map_bank = bb; map_key = pb; end
      S_WI_A: map_wdata = map_rdata;
      S_WI_B: begin map_bank = bb; map_key = pb; map_wdata = qa; end
      S_WF_A: begin map_fwd = 1'b1; map_bank = qa[BANK_W-1:0]; map_key = qa; map_wdata = pb; end
      S_WF_B: begin map_fwd = 1'b1; map_bank = qb[BANK_W-1:0]; map_key = qb; map_wdata = pa; end
      default: begin map_valid = 1'b0; map_we = 1'b0; end
    endcase
  end

  assign msg_valid  = (state == S_NOTIFY) && (send_pend != '0);
  assign msg_core   = next_core;
  assign msg_os_a   = qa;
  assign msg_l2_a   = pb;
  assign msg_os_b   = qb;
  assign msg_l2_b   = pa;
  assign xfer_valid = (state == S_XFER);
  assign xfer_blk   = beat[BEAT_W-1:1];
  assign xfer_dir   = beat[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ba        <= '0;
      bb        <= '0;
      pa        <= '0;
      pb        <= '0;
      qa        <= '0;
      qb        <= '0;
      union_r   <= '0;
      send_pend <= '0;
      ack_pend  <= '0;
      beat      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ba      <= bank_a;
          bb      <= bank_b;
          pa      <= page_a;
          pb      <= page_b;
          union_r <= sharers_a | sharers_b;
          state   <= S_RD_A;
        end
        S_RD_A: state <= S_RD_B;
        S_RD_B: begin qa <= map_rdata; state <= S_WI_A; end
        S_WI_A: begin qb <= map_rdata; state <= S_WI_B; end
        S_WI_B: state <= S_WF_A;
        S_WF_A: state <= S_WF_B;
        S_WF_B: begin
          send_pend <= union_r;
          ack_pend  <= union_r;
          state     <= S_NOTIFY;
        end
        S_NOTIFY: begin
          if (msg_valid && msg_ready)
            send_pend <= send_pend & ~(NCORES'(1) << next_core);
          ack_pend <= ack_pend & ~ack_mask;
          if (send_pend == '0 && ack_pend == '0) begin
            beat  <= '0;
            state <= S_XFER;
          end
        end
        S_XFER: if (xfer_ready) begin
          if (beat == LAST_BEAT) state <= S_DONE;
          else beat <= beat + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_stall_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|bank_stall) |-> $past(start));
  a_r3_map_only_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> (bank_stall != '0));
  a_r5_msg_to_sharer: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> union_r[msg_core]);
  a_r6_no_xfer_before_acks: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (ack_pend == '0) && (send_pend == '0));
  a_r7_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> xfer_valid && $stable(xfer_blk) && $stable(xfer_dir));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bank_stall == '0) && !xfer_valid);
endmodule

// File: tb/tb_page_swap_seq.sv
`timescale 1ns/1ps
module tb_page_swap_seq;
  localparam int NCORES = 8, NBANKS = 16, PPN_W = 20, BLOCKS = 64;
  localparam logic [PPN_W-1:0] MASK = 20'h5A5C3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] bank_a = 0, bank_b = 0, map_bank;
  logic [PPN_W-1:0] page_a = 0, page_b = 0, map_key, map_wdata, map_rdata;
  logic [NCORES-1:0] sharers_a = 0, sharers_b = 0;
  logic [NBANKS-1:0] bank_stall;
  logic map_valid, map_we, map_fwd, msg_valid, msg_ready = 1, xfer_valid, xfer_ready = 0;
  logic xfer_dir, done, ack_valid = 0;
  logic [2:0] msg_core, ack_core = 0;
  logic [PPN_W-1:0] msg_os_a, msg_l2_a, msg_os_b, msg_l2_b;
  logic [5:0] xfer_blk;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  always @(posedge clk)
    if (map_valid && !map_we) map_rdata <= map_key ^ MASK;

  page_swap_seq #(.NCORES(NCORES), .NBANKS(NBANKS), .PPN_W(PPN_W), .BLOCKS(BLOCKS)) dut (
    .clk, .rst_n, .start, .bank_a, .page_a, .sharers_a, .bank_b, .page_b, .sharers_b,
    .bank_stall, .map_valid, .map_we, .map_fwd, .map_bank, .map_key, .map_wdata, .map_rdata,
    .msg_valid, .msg_ready, .msg_core, .msg_os_a, .msg_l2_a, .msg_os_b, .msg_l2_b,
    .ack_valid, .ack_core, .xfer_valid, .xfer_ready, .xfer_blk, .xfer_dir, .done);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_map(input string req, input bit we, input bit fwd,
                         input logic [3:0] bk, input logic [PPN_W-1:0] key,
                         input logic [PPN_W-1:0] wd);
    chk(map_valid && map_we == we && map_fwd == fwd, req, "map op",
        {map_valid, map_we, map_fwd}, {1'b1, we, fwd});
    chk(map_bank == bk && map_key == key, req, "map addr", {map_bank, map_key}, {bk, key});
    if (we) chk(map_wdata == wd, req, "map wdata", map_wdata, wd);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bank_stall == 0 && !map_valid && !msg_valid && !xfer_valid && !done, "R1",
        "idle outputs", {bank_stall, map_valid, msg_valid, xfer_valid, done}, 0);
  endtask

  task automatic t_swap(input logic [3:0] ba, input logic [3:0] bb,
                        input logic [PPN_W-1:0] pa, input logic [PPN_W-1:0] pb,
                        input logic [7:0] sa, input logic [7:0] sb,
                        input bit gaps, input int bogus, input bit restart);
    logic [PPN_W-1:0] qa = pa ^ MASK, qb = pb ^ MASK;
    logic [NBANKS-1:0] st = (NBANKS'(1) << ba) | (NBANKS'(1) << bb);
    logic [7:0] un = sa | sb;
    int exp = 0, cyc = 0, wait_n = 0;
    bank_a = ba; bank_b = bb; page_a = pa; page_b = pb; sharers_a = sa; sharers_b = sb;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(bank_stall == st, "R2", "stall set", bank_stall, st);
    chk_map("R3", 0, 0, ba, pa, 0);
    @(negedge clk); chk_map("R3", 0, 0, bb, pb, 0);
    @(negedge clk); chk_map("R3", 1, 0, ba, pa, qb);
    @(negedge clk); chk_map("R3", 1, 0, bb, pb, qa);
    @(negedge clk); chk_map("R4", 1, 1, qa[3:0], qa, pb);
    @(negedge clk); chk_map("R4", 1, 1, qb[3:0], qb, pa);
    @(negedge clk);
    for (int i = 0; i < NCORES; i++) begin
      if (un[i]) begin
        chk(msg_valid && msg_core == 3'(i), "R5", "msg core", {msg_valid, msg_core}, {1'b1, 3'(i)});
        chk(msg_os_a == qa && msg_l2_a == pb && msg_os_b == qb && msg_l2_b == pa, "R5",
            "msg fields", msg_os_a, qa);
        chk(!xfer_valid, "R6", "xfer during notify", xfer_valid, 0);
        @(negedge clk);
      end
    end
    if (un != 0) begin
      chk(!msg_valid, "R5", "extra message", msg_valid, 0);
      if (bogus >= 0) begin
        ack_valid = 1; ack_core = 3'(bogus);
        @(negedge clk);
        ack_valid = 0;
        repeat (2) @(negedge clk);
        chk(!xfer_valid && bank_stall == st, "R6", "stray ack released wait", xfer_valid, 0);
      end
      for (int i = 0; i < NCORES; i++) begin
        if (un[i]) begin
          chk(!xfer_valid, "R6", "xfer before all acks", xfer_valid, 0);
          ack_valid = 1; ack_core = 3'(i);
          @(negedge clk);
        end
      end
      ack_valid = 0;
    end else begin
      chk(!msg_valid, "R9", "message with no sharers", msg_valid, 0);
    end
    while (!xfer_valid && wait_n < 4) begin @(negedge clk); wait_n++; end
    chk(xfer_valid, un == 0 ? "R9" : "R6", "transfer started", xfer_valid, 1);
    while (exp < 2 * BLOCKS && cyc < 1000) begin
      xfer_ready = gaps ? (cyc % 3 != 0) : 1'b1;
      start = restart && (exp == 10);
      chk(xfer_valid && xfer_blk == 6'(exp / 2) && xfer_dir == exp[0], "R7", "beat",
          {xfer_valid, xfer_blk, xfer_dir}, {1'b1, 6'(exp / 2), exp[0]});
      if (exp < 2 * BLOCKS - 1)
        chk(!done && bank_stall == st, "R2", "stall held", bank_stall, st);
      if (xfer_ready) exp++;
      cyc++;
      @(negedge clk);
    end
    start = 0;
    xfer_ready = 0;
    chk(done && bank_stall == 0 && !xfer_valid, "R8", "done and release",
        {done, bank_stall}, {1'b1, 16'h0});
    @(negedge clk);
    chk(!done, "R8", "done single pulse", done, 0);
    repeat (3) begin
      chk(bank_stall == 0 && !map_valid, "R2", "start while busy ignored",
          {bank_stall, map_valid}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_swap(4'd2, 4'd11, 20'h12345, 20'h0ABCD, 8'h05, 8'h44, 0, -1, 1);
    t_swap(4'd7, 4'd0, 20'hFEDCB, 20'h00042, 8'h00, 8'h00, 1, -1, 0);
    t_swap(4'd15, 4'd5, 20'h33333, 20'h7777A, 8'h81, 8'h10, 1, 3, 0);
    t_swap(4'd1, 4'd9, 20'h0F0F0, 20'hA0A0A, 8'hFF, 8'h00, 0, -1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule